// File: doc/BRIEF.md
# Streaming Port Mode and Handshake Controller

This block holds the control word of a parallel streaming data port and turns it into the port's mode and handshake policy. Software writes a 9-bit control word and a data-valid idle limit through a simple write strobe. The block decodes one of three operating modes: FIFO loopback, receive or transmit. It drives the receive-side not-ready and transmit-side sync outputs straight from the control word. It raises a transmit enable that the far end's suspend and not-ready requests may stall, but only when each of those stalls has been enabled on its own.

The far-end handshakes (direction, suspend, not-ready, sync) and the active-low data-valid line are first passed through synchronisers. A sync falling edge can be chosen to mark the start of a frame. The FIFO clear output is active low. Software can hold it low directly. When enabled, an idle timer also pulses it low for one cycle once data-valid has stayed inactive for a programmable number of clock edges. The synchronised direction, suspend and not-ready levels are returned in the upper bits of the control readback.

Top module: `stream_port_ctrl`

## Requirements
- R1: Control bits [1:0] select the mode. 00 asserts `mode_loop`, 01 asserts `mode_rx` and 10 asserts `mode_tx`. Value 11 asserts none of the three, and at most one is ever high.
- R2: `rx_nrdy_n` follows control bit 2 and `tx_sync_n` follows control bit 3.
- R3: A write with `wr_sel`=0 loads control bits [8:0] from `wr_data[8:0]`, and a write with `wr_sel`=1 loads the idle limit from `wr_data`. After reset the control bits read 9'h088 and the limit reads DLY_RST (17500 by default). Both registers are visible on `ctrl_rdata[8:0]` and `delay_rdata` on the cycle after the write edge.
- R4: `tx_enable` is high only in transmit mode. It is low while bit 4 is set and the synchronised suspend is low, or while bit 5 is set and the synchronised not-ready is low. With a stall bit clear, its handshake has no effect.
- R5: When bit 6 is set, a high-to-low transition of the synchronised sync input gives a one-cycle `frame_start` pulse. With bit 6 clear, sync is ignored and `frame_start` stays low.
- R6: While control bit 7 is 0, `fifo_clr_n` is held low.
- R7: With bit 8 set, `fifo_clr_n` is low for exactly one cycle once the synchronised `dvalid_n` has been high on limit+1 consecutive clock edges. With bit 8 clear, no automatic clear is issued.
- R8: Each idle period gives at most one automatic clear pulse. An active (low) synchronised `dvalid_n` restarts the idle count and re-arms the timer.
- R9: Every far-end input and `dvalid_n` reaches the logic through SYNC_STAGES flops (2 by default). `ctrl_rdata[9]`, `[10]` and `[11]` report the synchronised direction, suspend and not-ready levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the idle limit |
| wr_data | input | DLY_W | Write data |
| ctrl_rdata | output | 12 | Control word readback with live handshake status in [11:9] |
| delay_rdata | output | DLY_W | Idle limit readback |
| far_dir_n | input | 1 | Far-end direction input |
| far_suspend_n | input | 1 | Far-end suspend request, active low |
| far_nrdy_n | input | 1 | Far-end not-ready, active low |
| far_sync_n | input | 1 | Incoming sync strobe, active low |
| dvalid_n | input | 1 | Data-valid, active low |
| mode_loop | output | 1 | Loopback mode selected |
| mode_rx | output | 1 | Receive mode selected |
| mode_tx | output | 1 | Transmit mode selected |
| rx_nrdy_n | output | 1 | Receive-side not-ready output |
| tx_sync_n | output | 1 | Transmit-side sync output |
| tx_enable | output | 1 | Transmitter may send |
| frame_start | output | 1 | One-cycle frame start marker |
| fifo_clr_n | output | 1 | FIFO clear, active low |

## Verification
The assertions watch several relations on every cycle. The three mode flags stay mutually exclusive, and transmit enable never appears outside transmit mode or while an enabled suspend stall is active. Frame-start pulses last one cycle and never occur with bit 6 clear. The FIFO clear follows the software clear bit, and automatic clear pulses are never back to back or issued while the timeout is disabled. Some behaviours need the bench's reference model with timed stimulus: the exact edge on which the idle timeout fires for a given limit, the re-arming after a short burst of data-valid, the two-edge synchroniser latency, and readback of written values.

// File: rtl/stream_port_pkg.sv
package stream_port_pkg;

   typedef enum logic [1:0] {
      PM_LOOP = 2'b00,
      PM_RX   = 2'b01,
      PM_TX   = 2'b10,
      PM_RSVD = 2'b11
   } port_mode_e;

   typedef struct packed {
      logic       auto_clr_en;
      logic       fifo_keep_n;
      logic       sync_frame_en;
      logic       nrdy_stall_en;
      logic       susp_stall_en;
      logic       tx_sync_n;
      logic       rx_nrdy_n;
      port_mode_e mode;
   } port_ctrl_t;

   localparam int unsigned CTRL_W = $bits(port_ctrl_t);
   localparam logic [CTRL_W-1:0] CTRL_RST = 9'h088;

   localparam int unsigned IN_DIR  = 0;
   localparam int unsigned IN_SUSP = 1;
   localparam int unsigned IN_NRDY = 2;
   localparam int unsigned IN_SYNC = 3;
   localparam int unsigned IN_DV   = 4;
   localparam int unsigned IN_W    = 5;

endpackage

// File: rtl/stream_port_sync.sv
module stream_port_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("stream_port_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= RST_VAL;
         end else if (s == 0) begin
            stage_q[s] <= d_in;
         end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/stream_port_regs.sv
module stream_port_regs
   import stream_port_pkg::*;
#(
   parameter int unsigned DLY_W   = 16,
   parameter logic [DLY_W-1:0] DLY_RST = 16'd17500
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [DLY_W-1:0] wr_data,
   output port_ctrl_t       ctrl_q,
   output logic [DLY_W-1:0] limit_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= port_ctrl_t'(CTRL_RST);
         limit_q <= DLY_RST;
      end else if (wr_en) begin
         if (wr_sel) begin
            limit_q <= wr_data;
         end else begin
            ctrl_q <= port_ctrl_t'(wr_data[CTRL_W-1:0]);
         end
      end
   end

endmodule

// File: rtl/stream_port_idle.sv
module stream_port_idle #(
   parameter int unsigned DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             dv_idle,
   input  logic [DLY_W-1:0] limit,
   output logic             clr_pulse
);

   localparam logic [DLY_W-1:0] CNT_MAX = '1;

   logic [DLY_W-1:0] idle_cnt;
   logic             fired;
   logic             hit;

   assign hit = enable && !fired && (idle_cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_cnt  <= '0;
         fired     <= 1'b0;
         clr_pulse <= 1'b0;
      end else if (!dv_idle) begin
         idle_cnt  <= '0;
         fired     <= 1'b0;
         clr_pulse <= 1'b0;
      end else begin
         if (idle_cnt != CNT_MAX) begin
            idle_cnt <= idle_cnt + 1'b1;
         end
         clr_pulse <= hit;
         if (hit) begin
            fired <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/stream_port_ctrl.sv
module stream_port_ctrl
   import stream_port_pkg::*;
#(
   parameter int unsigned DLY_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [DLY_W-1:0] DLY_RST = 16'd17500
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [DLY_W-1:0] wr_data,
   output logic [11:0]      ctrl_rdata,
   output logic [DLY_W-1:0] delay_rdata,
   input  logic             far_dir_n,
   input  logic             far_suspend_n,
   input  logic             far_nrdy_n,
   input  logic             far_sync_n,
   input  logic             dvalid_n,
   output logic             mode_loop,
   output logic             mode_rx,
   output logic             mode_tx,
   output logic             rx_nrdy_n,
   output logic             tx_sync_n,
   output logic             tx_enable,
   output logic             frame_start,
   output logic             fifo_clr_n
);

   if (DLY_W < CTRL_W || DLY_W > 32) begin : g_bad_width
      $error("stream_port_ctrl: DLY_W must lie between 9 and 32");
   end

   port_ctrl_t       ctrl;
   logic [DLY_W-1:0] limit;
   logic [IN_W-1:0]  raw_in;
   logic [IN_W-1:0]  syn;
   logic             sync_prev;
   logic             auto_pulse;
   logic             stall;

   assign raw_in = {dvalid_n, far_sync_n, far_nrdy_n, far_suspend_n, far_dir_n};

   stream_port_sync #(
      .WIDTH  (IN_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL('1)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_in (raw_in),
      .d_out(syn)
   );

   stream_port_regs #(
      .DLY_W  (DLY_W),
      .DLY_RST(DLY_RST)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .wr_data(wr_data),
      .ctrl_q (ctrl),
      .limit_q(limit)
   );

   stream_port_idle #(
      .DLY_W(DLY_W)
   ) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (ctrl.auto_clr_en),
      .dv_idle  (syn[IN_DV]),
      .limit    (limit),
      .clr_pulse(auto_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_prev <= 1'b1;
      end else begin
         sync_prev <= syn[IN_SYNC];
      end
   end

   assign mode_loop = (ctrl.mode == PM_LOOP);
   assign mode_rx   = (ctrl.mode == PM_RX);
   assign mode_tx   = (ctrl.mode == PM_TX);

   assign stall = (ctrl.susp_stall_en && !syn[IN_SUSP])
               || (ctrl.nrdy_stall_en && !syn[IN_NRDY]);

   assign tx_enable   = mode_tx && !stall;
   assign rx_nrdy_n   = ctrl.rx_nrdy_n;
   assign tx_sync_n   = ctrl.tx_sync_n;
   assign frame_start = ctrl.sync_frame_en && sync_prev && !syn[IN_SYNC];
   assign fifo_clr_n  = ctrl.fifo_keep_n && !auto_pulse;

   assign ctrl_rdata  = {syn[IN_NRDY], syn[IN_SUSP], syn[IN_DIR], ctrl};
   assign delay_rdata = limit;

endmodule

// File: rtl/stream_port_ctrl_chk.sv
module stream_port_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [11:0] ctrl_rdata,
   input logic        mode_loop,
   input logic        mode_rx,
   input logic        mode_tx,
   input logic        tx_enable,
   input logic        frame_start,
   input logic        fifo_clr_n
);

   assert_mode_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mode_loop, mode_rx, mode_tx}));

   assert_tx_only_in_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_enable |-> mode_tx);

   assert_susp_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rdata[4] && !ctrl_rdata[10]) |-> !tx_enable);

   assert_frame_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);

   assert_frame_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_rdata[6] |-> !frame_start);

   assert_sw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_rdata[7] |-> !fifo_clr_n);

   assert_auto_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rdata[7] && !ctrl_rdata[8] && !$past(ctrl_rdata[8])) |-> fifo_clr_n);

   assert_pulse_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rdata[7] && !fifo_clr_n) |=> (fifo_clr_n || !ctrl_rdata[7]));

endmodule

bind stream_port_ctrl stream_port_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctrl_rdata (ctrl_rdata),
   .mode_loop  (mode_loop),
   .mode_rx    (mode_rx),
   .mode_tx    (mode_tx),
   .tx_enable  (tx_enable),
   .frame_start(frame_start),
   .fifo_clr_n (fifo_clr_n)
);

// File: tb/stream_port_ctrl_tb_top.sv
module stream_port_ctrl_tb_top;

   localparam int DW      = 16;
   localparam int RST_LIM = 17500;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          wr_sel = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          far_dir_n = 1'b1, far_suspend_n = 1'b1, far_nrdy_n = 1'b1;
   logic          far_sync_n = 1'b1, dvalid_n = 1'b1;
   logic [11:0]   ctrl_rdata;
   logic [DW-1:0] delay_rdata;
   logic          mode_loop, mode_rx, mode_tx, rx_nrdy_n, tx_sync_n;
   logic          tx_enable, frame_start, fifo_clr_n;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   stream_port_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .ctrl_rdata(ctrl_rdata), .delay_rdata(delay_rdata),
      .far_dir_n(far_dir_n), .far_suspend_n(far_suspend_n), .far_nrdy_n(far_nrdy_n),
      .far_sync_n(far_sync_n), .dvalid_n(dvalid_n),
      .mode_loop(mode_loop), .mode_rx(mode_rx), .mode_tx(mode_tx),
      .rx_nrdy_n(rx_nrdy_n), .tx_sync_n(tx_sync_n), .tx_enable(tx_enable),
      .frame_start(frame_start), .fifo_clr_n(fifo_clr_n)
   );

   // Behavioural reference: two delayed copies of each input, integer idle count.
   logic [8:0] m_ctrl;
   int         m_lim;
   bit         m_dir[2], m_susp[2], m_nrdy[2], m_sync[2], m_dv[2];
   bit         m_prev;
   int         m_cnt;
   bit         m_fired, m_pulse;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl = 9'h088; m_lim = RST_LIM;
         foreach (m_dir[i]) begin
            m_dir[i] = 1; m_susp[i] = 1; m_nrdy[i] = 1; m_sync[i] = 1; m_dv[i] = 1;
         end
         m_prev = 1; m_cnt = 0; m_fired = 0; m_pulse = 0;
      end else begin
         if (!m_dv[1]) begin
            m_cnt = 0; m_fired = 0; m_pulse = 0;
         end else begin
            m_pulse = m_ctrl[8] && !m_fired && (m_cnt >= m_lim);
            if (m_pulse) m_fired = 1;
            if (m_cnt < 65535) m_cnt++;
         end
         m_prev = m_sync[1];
         m_dir[1] = m_dir[0];   m_dir[0] = far_dir_n;
         m_susp[1] = m_susp[0]; m_susp[0] = far_suspend_n;
         m_nrdy[1] = m_nrdy[0]; m_nrdy[0] = far_nrdy_n;
         m_sync[1] = m_sync[0]; m_sync[0] = far_sync_n;
         m_dv[1] = m_dv[0];     m_dv[0] = dvalid_n;
         if (wr_en) begin
            if (wr_sel) m_lim = int'(wr_data);
            else        m_ctrl = wr_data[8:0];
         end
      end
   end

   task automatic check1(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         bit e_tx;
         e_tx = (m_ctrl[1:0] == 2'b10) && !(m_ctrl[4] && !m_susp[1]) && !(m_ctrl[5] && !m_nrdy[1]);
         check1("R1", "mode flags", {mode_loop, mode_rx, mode_tx},
                {m_ctrl[1:0] == 2'b00, m_ctrl[1:0] == 2'b01, m_ctrl[1:0] == 2'b10});
         check1("R2", "nrdy/sync outs", {rx_nrdy_n, tx_sync_n}, {m_ctrl[2], m_ctrl[3]});
         check1("R3", "delay_rdata", int'(delay_rdata), m_lim);
         check1("R4", "tx_enable", tx_enable, e_tx);
         check1("R5", "frame_start", frame_start, m_ctrl[6] && m_prev && !m_sync[1]);
         check1("R6_R7_R8", "fifo_clr_n", fifo_clr_n, m_ctrl[7] && !m_pulse);
         check1("R9", "ctrl_rdata", int'(ctrl_rdata), {m_nrdy[1], m_susp[1], m_dir[1], m_ctrl});
      end
   end

   task automatic tick(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(bit sel, int data);
      @(negedge clk);
      wr_en = 1; wr_sel = sel; wr_data = DW'(data);
      @(negedge clk);
      wr_en = 0;
   endtask

   initial begin
      tick(3);
      // R3: reset values
      check1("R3", "reset ctrl_rdata", int'(ctrl_rdata), 12'hE88);
      check1("R3", "reset delay_rdata", int'(delay_rdata), RST_LIM);
      rst_n = 1;
      tick(4);
      // R1 / R2: each mode and the two direct output bits
      wr(0, 9'h081); tick(2);
      wr(0, 9'h086); tick(2);
      wr(0, 9'h08B); tick(2);
      wr(0, 9'h080); tick(2);
      // R4: transmit with stalls disabled, then enabled one at a time
      wr(0, 9'h08A);
      far_suspend_n = 0; far_nrdy_n = 0; tick(4);
      wr(0, 9'h09A); tick(3);
      far_suspend_n = 1; tick(3);
      wr(0, 9'h0AA); tick(3);
      far_nrdy_n = 1; tick(3);
      wr(0, 9'h0BA); far_nrdy_n = 0; tick(1); far_nrdy_n = 1; tick(4);
      // R9: direction status latency
      far_dir_n = 0; tick(4); far_dir_n = 1; tick(4);
      // R5: sync ignored, then used
      far_sync_n = 0; tick(3); far_sync_n = 1; tick(3);
      wr(0, 9'h0C9);
      far_sync_n = 0; tick(4); far_sync_n = 1; tick(2);
      far_sync_n = 0; tick(1); far_sync_n = 1; tick(4);
      // R6: software clear
      wr(0, 9'h009); tick(3);
      wr(0, 9'h089); tick(2);
      // R7 / R8: idle timeout with limit 5
      dvalid_n = 0;
      wr(1, 5);
      wr(0, 9'h189); tick(4);
      dvalid_n = 1; tick(20);
      dvalid_n = 0; tick(2); dvalid_n = 1; tick(3);
      dvalid_n = 0; tick(3); dvalid_n = 1; tick(12);
      // R7: limit 0 fires on the first idle edge
      dvalid_n = 0; wr(1, 0); tick(3);
      dvalid_n = 1; tick(6);
      dvalid_n = 0; tick(1); dvalid_n = 1; tick(6);
      // R7: disabled timeout gives nothing, enabling late fires at once
      wr(0, 9'h089); dvalid_n = 0; tick(3); dvalid_n = 1; tick(10);
      wr(0, 9'h189); tick(5);
      // R3: readback of an arbitrary limit
      wr(1, 16'hBEEF); tick(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule